// File: doc/BRIEF.md
# Nibble-Addressed Branch and Return Unit

This unit decides the next program counter for a processor whose memory is addressed in 4-bit nibbles with 20-bit addresses. Each cycle in which `op_valid` is high it takes the address of the current instruction, a code that says which kind of control transfer the instruction is, a condition result that is evaluated elsewhere, up to four offset nibbles and five absolute-address nibbles taken from the instruction stream, a 20-bit register value and the instruction length. From these it forms the next PC. It also owns the hardware return-address stack.

The offset used by each relative form is added to a base that is specific to that form. Conditional branches use the address of their offset field. Calls use the address of the following instruction. A conditional branch that is taken with a zero offset does not jump. It acts as a return and takes its target from the top of the stack. Returns can also request a flag side effect, such as setting or clearing carry, which the unit reports to the core. Register-direct swaps give the core the address of the next instruction to write back. Transfers that read memory for an indirect target present that target on `reg_val`.

All results are registered and appear together one clock after the request.

Top module: `nibpc_unit`

## Requirements
- R1: After synchronous reset `nxt_vld`, `reg_wr_en` and `fx_code` are 0 and the return stack is empty.
- R2: `op_kind` encoding: 0 sequential, 1 carry branch, 2 short conditional branch, 3 long bit-test branch, 4 3-nibble jump, 5 4-nibble jump, 6 3-nibble call, 7 4-nibble call, 8 absolute jump, 9 absolute call, 10 register jump, 11 register swap, 12 return, 13 push register, 14 pop register. The nibble fetched first is the least significant one, so stream nibble k sits in bits [4k+3:4k] of `off_nibs` and `abs_nibs`. A taken conditional branch (kinds 1, 2, 3) with a non-zero offset byte `off_nibs[7:0]` goes to `cur_pc` plus 1, 3 or 5 respectively plus that byte sign-extended.
- R3: A conditional branch whose `cond_true` is 0, and a kind 0 operation, go to `cur_pc + insn_len`.
- R4: A taken conditional branch whose `off_nibs[7:0]` is 00 pops the stack and goes to the popped address, with `fx_code` 0.
- R5: Kind 4 goes to `cur_pc + 1 + sext(off_nibs[11:0])`. Kind 5 goes to `cur_pc + 2 + sext(off_nibs[15:0])`.
- R6: Kind 6 goes to `cur_pc + 4 + sext(off_nibs[11:0])` and pushes `cur_pc + 4`. Kind 7 goes to `cur_pc + 6 + sext(off_nibs[15:0])` and pushes `cur_pc + 6`.
- R7: Kind 8 goes to `abs_nibs`. Kind 9 goes to `abs_nibs` and pushes `cur_pc + 7`.
- R8: Kinds 10 and 11 go to `reg_val`. Kind 11 also gives `reg_wr_en` = 1 with `reg_wr_data = cur_pc + insn_len`.
- R9: Kind 12 pops the stack and goes to the popped address. `fx_code` repeats `ret_sel` when `ret_sel` is 1 (set carry), 2 (clear carry), 3 (set extended-mode flag) or 4 (enable interrupts), and is 0 for any other value.
- R10: Kind 13 pushes `reg_val`. Kind 14 pops into `reg_wr_data` with `reg_wr_en` = 1. Both go to `cur_pc + insn_len`.
- R11: The stack holds 8 addresses in last-in first-out order. A push onto a full stack discards the oldest entry. A pop from an empty stack yields 0 and leaves the stack empty.
- R12: All outputs are registered. `nxt_vld` is high exactly in the cycle after an `op_valid` cycle, and `reg_wr_en` and `fx_code` are only non-zero in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| op_kind | input | 4 | Control-transfer kind (R2) |
| cur_pc | input | 20 | Address of the current instruction |
| cond_true | input | 1 | Externally evaluated branch condition |
| off_nibs | input | 16 | Offset nibbles, first fetched in bits 3:0 |
| abs_nibs | input | 20 | Absolute-target nibbles, first fetched in bits 3:0 |
| reg_val | input | 20 | Register value or indirect target |
| insn_len | input | 4 | Instruction length in nibbles |
| ret_sel | input | 3 | Return side-effect select |
| nxt_vld | output | 1 | Next PC valid |
| nxt_pc | output | 20 | Next program counter |
| reg_wr_en | output | 1 | Register write-back request |
| reg_wr_data | output | 20 | Register write-back value |
| fx_code | output | 3 | Return side effect |

## Verification
Every result appears at the clock edge that follows the request cycle. These results are the next PC, the write-back value and the flag code, and the effect of a push or pop on the stack contents. The bench drives a request on a falling edge and checks all outputs on the next falling edge, which is exactly one register stage later. A stack change is observed on a later operation: the next pop, conditional return or register pop must return the value a queue model predicts. On idle cycles placed between operations the bench checks that the valid and side-effect outputs drop.

// File: rtl/nibpc_pkg.sv
package nibpc_pkg;

  typedef enum logic [3:0] {
    K_SEQ      = 4'd0,
    K_BR_CARRY = 4'd1,
    K_BR_SHORT = 4'd2,
    K_BR_LONG  = 4'd3,
    K_JMP3     = 4'd4,
    K_JMP4     = 4'd5,
    K_CALL3    = 4'd6,
    K_CALL4    = 4'd7,
    K_JMP_ABS  = 4'd8,
    K_CALL_ABS = 4'd9,
    K_JMP_REG  = 4'd10,
    K_SWAP_REG = 4'd11,
    K_RET      = 4'd12,
    K_PUSH_REG = 4'd13,
    K_POP_REG  = 4'd14
  } op_kind_e;

  typedef enum logic [2:0] {
    FX_NONE   = 3'd0,
    FX_SET_C  = 3'd1,
    FX_CLR_C  = 3'd2,
    FX_SET_XM = 3'd3,
    FX_INT_EN = 3'd4
  } fx_e;

  localparam int NIB_W     = 4;
  localparam int BR_OFF_W  = 8;
  localparam int SHORT_W   = 12;
  localparam int LONG_W    = 16;
  localparam int CALL3_LEN = 4;
  localparam int CALL4_LEN = 6;
  localparam int CALLA_LEN = 7;

  function automatic logic is_cond(op_kind_e k);
    return (k == K_BR_CARRY) || (k == K_BR_SHORT) || (k == K_BR_LONG);
  endfunction

endpackage

// File: rtl/nibpc_target.sv
module nibpc_target
  import nibpc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 16,
  parameter int LEN_W  = 4
) (
  input  op_kind_e            kind,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [OFF_W-1:0]    off,
  input  logic [ADDR_W-1:0]   abs_addr,
  input  logic [ADDR_W-1:0]   reg_in,
  input  logic [LEN_W-1:0]    len,
  output logic [ADDR_W-1:0]   tgt,
  output logic [ADDR_W-1:0]   link,
  output logic [ADDR_W-1:0]   seq
);

  logic [ADDR_W-1:0] off8_x, off12_x, off16_x;

  assign off8_x  = {{(ADDR_W-BR_OFF_W){off[BR_OFF_W-1]}}, off[BR_OFF_W-1:0]};
  assign off12_x = {{(ADDR_W-SHORT_W){off[SHORT_W-1]}}, off[SHORT_W-1:0]};
  assign off16_x = {{(ADDR_W-LONG_W){off[LONG_W-1]}}, off[LONG_W-1:0]};
  assign seq     = pc + ADDR_W'(len);

  always_comb begin
    tgt  = seq;
    link = seq;
    unique case (kind)
      K_BR_CARRY: tgt = pc + ADDR_W'(1) + off8_x;
      K_BR_SHORT: tgt = pc + ADDR_W'(3) + off8_x;
      K_BR_LONG:  tgt = pc + ADDR_W'(5) + off8_x;
      K_JMP3:     tgt = pc + ADDR_W'(1) + off12_x;
      K_JMP4:     tgt = pc + ADDR_W'(2) + off16_x;
      K_CALL3: begin
        link = pc + ADDR_W'(CALL3_LEN);
        tgt  = link + off12_x;
      end
      K_CALL4: begin
        link = pc + ADDR_W'(CALL4_LEN);
        tgt  = link + off16_x;
      end
      K_JMP_ABS:  tgt = abs_addr;
      K_CALL_ABS: begin
        link = pc + ADDR_W'(CALLA_LEN);
        tgt  = abs_addr;
      end
      K_JMP_REG, K_SWAP_REG: tgt = reg_in;
      default: tgt = seq;
    endcase
  end

endmodule

// File: rtl/nibpc_retstack.sv
module nibpc_retstack #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp;
  logic [CW-1:0] cnt;
  logic [PW-1:0] wp_inc, wp_dec;

  assign wp_inc   = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
  assign wp_dec   = (wp == '0) ? PW'(DEPTH - 1) : wp - PW'(1);
  assign top_data = (cnt == '0) ? '0 : mem[wp_dec];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      cnt <= '0;
    end else if (push) begin
      wp <= wp_inc;
      if (cnt != CW'(DEPTH)) cnt <= cnt + CW'(1);
    end else if (pop && cnt != '0) begin
      wp  <= wp_dec;
      cnt <= cnt - CW'(1);
    end
  end

  p_one_port_r11: assert property (@(posedge clk) disable iff (rst) !(push && pop));
  p_depth_bound_r11: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));
  p_push_nonempty_r11: assert property (@(posedge clk) disable iff (rst) push |=> cnt != '0);
  p_full_stays_full_r11: assert property (@(posedge clk) disable iff (rst)
    (push && cnt == CW'(DEPTH)) |=> cnt == CW'(DEPTH));
  p_empty_pop_stays_r11: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/nibpc_unit.sv
module nibpc_unit
  import nibpc_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int OFF_W       = 16,
  parameter int LEN_W       = 4,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_kind,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              cond_true,
  input  logic [OFF_W-1:0]  off_nibs,
  input  logic [ADDR_W-1:0] abs_nibs,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [2:0]        ret_sel,
  output logic              nxt_vld,
  output logic [ADDR_W-1:0] nxt_pc,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_data,
  output logic [2:0]        fx_code
);

  op_kind_e          kind;
  logic [ADDR_W-1:0] tgt, link, seq, top_data, push_data;
  logic              push, pop, wr_n;
  logic [ADDR_W-1:0] pc_n, wrd_n;
  fx_e               fx_n;
  logic              off_zero;

  assign kind     = op_kind_e'(op_kind);
  assign off_zero = (off_nibs[BR_OFF_W-1:0] == '0);

  nibpc_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_tgt (
    .kind(kind), .pc(cur_pc), .off(off_nibs), .abs_addr(abs_nibs),
    .reg_in(reg_val), .len(insn_len), .tgt(tgt), .link(link), .seq(seq)
  );

  nibpc_retstack #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(pop), .top_data(top_data)
  );

  always_comb begin
    push      = 1'b0;
    pop       = 1'b0;
    push_data = link;
    pc_n      = seq;
    wr_n      = 1'b0;
    wrd_n     = '0;
    fx_n      = FX_NONE;
    if (op_valid) begin
      unique case (kind)
        K_BR_CARRY, K_BR_SHORT, K_BR_LONG: begin
          if (cond_true && off_zero) begin
            pop  = 1'b1;
            pc_n = top_data;
          end else if (cond_true) begin
            pc_n = tgt;
          end
        end
        K_JMP3, K_JMP4, K_JMP_ABS, K_JMP_REG: pc_n = tgt;
        K_CALL3, K_CALL4, K_CALL_ABS: begin
          pc_n = tgt;
          push = 1'b1;
        end
        K_SWAP_REG: begin
          pc_n  = tgt;
          wr_n  = 1'b1;
          wrd_n = seq;
        end
        K_RET: begin
          pop  = 1'b1;
          pc_n = top_data;
          if (ret_sel >= 3'd1 && ret_sel <= 3'd4) fx_n = fx_e'(ret_sel);
        end
        K_PUSH_REG: begin
          push      = 1'b1;
          push_data = reg_val;
        end
        K_POP_REG: begin
          pop   = 1'b1;
          wr_n  = 1'b1;
          wrd_n = top_data;
        end
        default: pc_n = seq;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_vld     <= 1'b0;
      nxt_pc      <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      fx_code     <= 3'd0;
    end else begin
      nxt_vld     <= op_valid;
      nxt_pc      <= pc_n;
      reg_wr_en   <= wr_n;
      reg_wr_data <= wrd_n;
      fx_code     <= fx_n;
    end
  end

  p_vld_follows_r12: assert property (@(posedge clk) disable iff (rst) op_valid |=> nxt_vld);
  p_vld_idle_r12: assert property (@(posedge clk) disable iff (rst) !op_valid |=> !nxt_vld);
  p_wr_needs_vld_r12: assert property (@(posedge clk) disable iff (rst) reg_wr_en |-> nxt_vld);
  p_fx_needs_vld_r9: assert property (@(posedge clk) disable iff (rst) (fx_code != 3'd0) |-> nxt_vld);
  p_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_cond(kind) && !cond_true) |=> nxt_pc == $past(cur_pc + ADDR_W'(insn_len)));
  p_abs_jump_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && kind == K_JMP_ABS) |=> nxt_pc == $past(abs_nibs));

endmodule

// File: tb/nibpc_unit_tb_top.sv
module nibpc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_kind = 4'd0;
  logic [19:0] cur_pc = '0;
  logic        cond_true = 1'b0;
  logic [15:0] off_nibs = '0;
  logic [19:0] abs_nibs = '0;
  logic [19:0] reg_val = '0;
  logic [3:0]  insn_len = 4'd2;
  logic [2:0]  ret_sel = 3'd0;
  logic        nxt_vld, reg_wr_en;
  logic [19:0] nxt_pc, reg_wr_data;
  logic [2:0]  fx_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [19:0] mstk[$];

  always #4 clk = ~clk;

  nibpc_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .cur_pc(cur_pc),
    .cond_true(cond_true), .off_nibs(off_nibs), .abs_nibs(abs_nibs), .reg_val(reg_val),
    .insn_len(insn_len), .ret_sel(ret_sel), .nxt_vld(nxt_vld), .nxt_pc(nxt_pc),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .fx_code(fx_code)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] sx(logic [15:0] v, int w);
    logic [19:0] r;
    r = 20'(v);
    for (int i = w; i < 20; i++) r[i] = v[w-1];
    return r;
  endfunction

  function automatic logic [19:0] mpop();
    if (mstk.size() == 0) return 20'h0;
    return mstk.pop_back();
  endfunction

  function automatic void mpush(logic [19:0] v);
    if (mstk.size() == 8) void'(mstk.pop_front());
    mstk.push_back(v);
  endfunction

  // one operation: drive on a falling edge, check on the next falling edge
  task automatic do_op(int k, logic [19:0] pc, bit c, logic [15:0] off,
                       logic [19:0] ab, logic [19:0] rv, logic [3:0] ln, logic [2:0] rs);
    logic [19:0] e_pc, e_wd;
    bit e_wr;
    logic [2:0] e_fx;
    string tag;
    op_valid = 1'b1; op_kind = 4'(k); cur_pc = pc; cond_true = c;
    off_nibs = off; abs_nibs = ab; reg_val = rv; insn_len = ln; ret_sel = rs;
    e_pc = pc + 20'(ln); e_wr = 0; e_wd = '0; e_fx = 3'd0; tag = "R3";
    case (k)
      1, 2, 3: begin
        if (c && off[7:0] == 8'h00) begin e_pc = mpop(); tag = "R4"; end
        else if (c) begin
          e_pc = pc + 20'((k == 1) ? 1 : (k == 2) ? 3 : 5) + sx(off, 8); tag = "R2";
        end
      end
      4: begin e_pc = pc + 20'd1 + sx(off, 12); tag = "R5"; end
      5: begin e_pc = pc + 20'd2 + sx(off, 16); tag = "R5"; end
      6: begin e_pc = pc + 20'd4 + sx(off, 12); mpush(pc + 20'd4); tag = "R6"; end
      7: begin e_pc = pc + 20'd6 + sx(off, 16); mpush(pc + 20'd6); tag = "R6"; end
      8: begin e_pc = ab; tag = "R7"; end
      9: begin e_pc = ab; mpush(pc + 20'd7); tag = "R7"; end
      10: begin e_pc = rv; tag = "R8"; end
      11: begin e_pc = rv; e_wr = 1; e_wd = pc + 20'(ln); tag = "R8"; end
      12: begin e_pc = mpop(); e_fx = (rs >= 1 && rs <= 4) ? rs : 3'd0; tag = "R9"; end
      13: begin mpush(rv); tag = "R10"; end
      14: begin e_wr = 1; e_wd = mpop(); tag = "R10"; end
      default: tag = "R3";
    endcase
    @(negedge clk);
    chk({tag, " R12 vld"}, 32'(nxt_vld), 32'd1);
    chk({tag, " pc"}, 32'(nxt_pc), 32'(e_pc));
    chk({tag, " wr_en"}, 32'(reg_wr_en), 32'(e_wr));
    if (e_wr) chk({tag, " wr_data"}, 32'(reg_wr_data), 32'(e_wd));
    chk({tag, " fx"}, 32'(fx_code), 32'(e_fx));
    op_valid = 1'b0;
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R12 idle vld", 32'(nxt_vld), 32'd0);
    chk("R12 idle wr", 32'(reg_wr_en), 32'd0);
    chk("R12 idle fx", 32'(fx_code), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and empty stack
    chk("R1 vld", 32'(nxt_vld), 32'd0);
    chk("R1 wr", 32'(reg_wr_en), 32'd0);
    chk("R1 fx", 32'(fx_code), 32'd0);
    do_op(14, 20'h00100, 0, 16'h0, 20'h0, 20'h0, 4'd3, 3'd0); // R1 R11 empty pop gives 0
    // R2 branches, positive and negative
    do_op(1, 20'h01000, 1, 16'h00F6, 20'h0, 20'h0, 4'd3, 3'd0);
    do_op(2, 20'h01000, 1, 16'h0016, 20'h0, 20'h0, 4'd5, 3'd0);
    do_op(3, 20'h00002, 1, 16'h0080, 20'h0, 20'h0, 4'd7, 3'd0);
    do_op(2, 20'h01000, 0, 16'h0016, 20'h0, 20'h0, 4'd5, 3'd0); // R3
    // R5 R6 wrap and sign
    do_op(4, 20'hFFFFF, 0, 16'h0C1F, 20'h0, 20'h0, 4'd4, 3'd0);
    do_op(5, 20'h00010, 0, 16'h8000, 20'h0, 20'h0, 4'd6, 3'd0);
    do_op(6, 20'h12345, 0, 16'h0040, 20'h0, 20'h0, 4'd4, 3'd0);
    do_op(7, 20'h20000, 0, 16'hE020, 20'h0, 20'h0, 4'd6, 3'd0);
    do_op(9, 20'h30000, 0, 16'h0, 20'hC0020, 20'h0, 4'd7, 3'd0); // R7
    do_op(2, 20'h40000, 1, 16'hAB00, 20'h0, 20'h0, 4'd5, 3'd0); // R4 return pops
    do_op(12, 20'h40000, 0, 16'h0, 20'h0, 20'h0, 4'd2, 3'd1);   // R9 set carry
    do_op(12, 20'h40000, 0, 16'h0, 20'h0, 20'h0, 4'd2, 3'd4);   // R9 int enable
    do_op(12, 20'h40000, 0, 16'h0, 20'h0, 20'h0, 4'd2, 3'd6);   // R9 empty pop, no fx
    do_op(11, 20'h50000, 0, 16'h0, 20'h0, 20'hABCDE, 4'd4, 3'd0); // R8 swap
    idle_chk();
    // R11 overflow: 10 pushes then 10 pops
    for (int i = 0; i < 10; i++) do_op(13, 20'h60000, 0, 16'h0, 20'h0, 20'(i + 1), 4'd2, 3'd0);
    for (int i = 0; i < 10; i++) do_op(14, 20'h60000, 0, 16'h0, 20'h0, 20'h0, 4'd2, 3'd0);
    idle_chk();
    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [15:0] off;
      k = int'($urandom_range(0, 14));
      off = 16'($urandom);
      if ($urandom_range(0, 3) == 0) off[7:0] = 8'h00;
      do_op(k, 20'($urandom), bit'($urandom_range(0, 1)), off, 20'($urandom),
            20'($urandom), 4'($urandom_range(2, 7)), 3'($urandom_range(0, 7)));
      if ($urandom_range(0, 9) == 0) idle_chk();
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule